// File: doc/BRIEF.md
# Two-Band Tone Band Selector

This block takes a squared audio signal, the one-bit output of a zero-crossing comparator, and decides whether the tone present lies in a low band (about 300 Hz to 660 Hz) or a high band (about 900 Hz to 2150 Hz). It is meant to sit in front of a tone frequency counter, which needs to know which measurement period to use.

The block counts rising crossings inside fixed evaluation windows. A window lasts 35,080 system clocks, which is about 9.8 ms at a 3.579545 MHz clock. At the end of each window the count is classified as low band, high band or neither. The band decision is sticky. It moves only when a window shows clear evidence of the other band, and a count in the gap between the bands never changes it. A band change raises a one-cycle pulse so the downstream timer and counter can restart their measurement. A separate flag reports whether the last window fell inside either band.

Monitoring runs without pause from reset. The first valid decision appears one window after reset.

Top module: `band_selector`

## Requirements
- R1: While reset is asserted, and until the first window completes, `band_hi` is 0 (low band), `in_band` is 0 and `band_chg` is 0.
- R2: Windows are exactly `WIN_CYCLES` clocks long and run back to back from reset release. The outputs change only on the clock edge that follows the last cycle of a window, and they hold their values through every other cycle.
- R3: A window with a rising-edge count from `LO_MIN` to `LO_MAX` inclusive (3 to 6 by default) sets `in_band` to 1 and `band_hi` to 0.
- R4: A window with a count from `HI_MIN` to `HI_MAX` inclusive (9 to 21 by default) sets `in_band` to 1 and `band_hi` to 1.
- R5: A window with any other count (zero, the gap between the bands, or above `HI_MAX`) sets `in_band` to 0 and leaves `band_hi` unchanged.
- R6: A window classified in the band already held leaves `band_hi` unchanged and gives no `band_chg` pulse.
- R7: `band_chg` is high for exactly one clock, on the same edge where `band_hi` changes value, and never at any other time.
- R8: The crossing count saturates rather than wrapping. Any count above the counter range, for example 35 edges with a 5-bit counter, is treated as out of band.
- R9: Only low-to-high transitions of `sq_in` are counted. An input held high across many cycles counts once, whatever the pulse width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sq_in | input | 1 | Squared (zero-crossing) audio signal, asynchronous to clk |
| band_hi | output | 1 | Current band decision: 1 for high band, 0 for low band |
| band_chg | output | 1 | One-cycle pulse when the band decision flips |
| in_band | output | 1 | 1 when the last window fell inside either band |

## Verification
The bench builds the selector with a 160-cycle window and keeps the default thresholds and the two-stage synchronizer. The short window lets the bench run dozens of windows, so many band flips, gap counts and repeated same-band windows are covered in a short run.

Each window can carry up to 36 edges, and pulse widths vary from one cycle up to tens of cycles. This is enough to reach counter saturation past 31 edges and the long-high-level case. It also keeps every synchronized edge inside the window in which it was driven.

// File: rtl/band_sel_pkg.sv
package band_sel_pkg;

   typedef enum logic [1:0] {
      CLS_NONE = 2'd0,
      CLS_LO   = 2'd1,
      CLS_HI   = 2'd2
   } cls_t;

   typedef enum logic {
      BAND_LO = 1'b0,
      BAND_HI = 1'b1
   } band_t;

endpackage

// File: rtl/bsel_edge_sync.sv
module bsel_edge_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic sig_in,
   output logic rise_p
);
   logic sig_s;
   logic prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign sig_s = sig_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               chain_q <= '0;
            end else begin
               chain_q[0] <= sig_in;
               for (int k = 1; k < SYNC_STAGES; k++) begin
                  chain_q[k] <= chain_q[k-1];
               end
            end
         end
         assign sig_s = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b0;
      else     prev_q <= sig_s;
   end

   assign rise_p = sig_s & ~prev_q;
endmodule

// File: rtl/bsel_window_timer.sv
module bsel_window_timer #(
   parameter int WIN_CYCLES = 35080
) (
   input  logic clk,
   input  logic rst,
   output logic win_end
);
   localparam int TW = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
   localparam logic [TW-1:0] LAST = TW'(WIN_CYCLES - 1);

   logic [TW-1:0] tick_q;

   assign win_end = (tick_q == LAST);

   always_ff @(posedge clk) begin
      if (rst)          tick_q <= '0;
      else if (win_end) tick_q <= '0;
      else              tick_q <= tick_q + 1'b1;
   end
endmodule

// File: rtl/bsel_cross_counter.sv
module bsel_cross_counter #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rise_p,
   input  logic             win_end,
   output logic [CNT_W-1:0] tally
);
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;

   // count that includes an edge landing in the closing cycle, held at TOP
   assign tally = (rise_p && (cnt_q != TOP)) ? cnt_q + 1'b1 : cnt_q;

   always_ff @(posedge clk) begin
      if (rst)          cnt_q <= '0;
      else if (win_end) cnt_q <= '0;
      else              cnt_q <= tally;
   end
endmodule

// File: rtl/bsel_classifier.sv
module bsel_classifier
   import band_sel_pkg::*;
#(
   parameter int CNT_W  = 5,
   parameter int LO_MIN = 3,
   parameter int LO_MAX = 6,
   parameter int HI_MIN = 9,
   parameter int HI_MAX = 21
) (
   input  logic [CNT_W-1:0] tally,
   output cls_t             cls
);
   int unsigned n;

   always_comb begin
      n = int'(tally);
      if (n >= LO_MIN && n <= LO_MAX)      cls = CLS_LO;
      else if (n >= HI_MIN && n <= HI_MAX) cls = CLS_HI;
      else                                 cls = CLS_NONE;
   end
endmodule

// File: rtl/band_selector.sv
module band_selector
   import band_sel_pkg::*;
#(
   parameter int WIN_CYCLES  = 35080,
   parameter int LO_MIN      = 3,
   parameter int LO_MAX      = 6,
   parameter int HI_MIN      = 9,
   parameter int HI_MAX      = 21,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic sq_in,
   output logic band_hi,
   output logic band_chg,
   output logic in_band
);
   localparam int CNT_W = $clog2(HI_MAX + 2);

   generate
      if (WIN_CYCLES < 2) begin : g_bad_win
         $error("band_selector: WIN_CYCLES must be at least 2");
      end
      if (LO_MIN < 1 || LO_MIN > LO_MAX) begin : g_bad_lo
         $error("band_selector: low band limits out of order");
      end
      if (LO_MAX >= HI_MIN || HI_MIN > HI_MAX) begin : g_bad_hi
         $error("band_selector: high band must lie above the low band");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("band_selector: SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic             rise_p;
   logic             win_end;
   logic [CNT_W-1:0] tally;
   cls_t             cls;

   band_t band_q;
   logic  inb_q;
   logic  chg_q;

   bsel_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst   (rst),
      .sig_in(sq_in),
      .rise_p(rise_p)
   );

   bsel_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
      .clk    (clk),
      .rst    (rst),
      .win_end(win_end)
   );

   bsel_cross_counter #(.CNT_W(CNT_W)) u_count (
      .clk    (clk),
      .rst    (rst),
      .rise_p (rise_p),
      .win_end(win_end),
      .tally  (tally)
   );

   bsel_classifier #(
      .CNT_W (CNT_W),
      .LO_MIN(LO_MIN),
      .LO_MAX(LO_MAX),
      .HI_MIN(HI_MIN),
      .HI_MAX(HI_MAX)
   ) u_cls (
      .tally(tally),
      .cls  (cls)
   );

   // sticky decision: only an in-band verdict for the other band moves it
   always_ff @(posedge clk) begin
      if (rst) begin
         band_q <= BAND_LO;
         inb_q  <= 1'b0;
         chg_q  <= 1'b0;
      end else if (win_end) begin
         unique case (cls)
            CLS_LO: begin
               inb_q  <= 1'b1;
               chg_q  <= (band_q != BAND_LO);
               band_q <= BAND_LO;
            end
            CLS_HI: begin
               inb_q  <= 1'b1;
               chg_q  <= (band_q != BAND_HI);
               band_q <= BAND_HI;
            end
            default: begin
               inb_q <= 1'b0;
               chg_q <= 1'b0;
            end
         endcase
      end else begin
         chg_q <= 1'b0;
      end
   end

   assign band_hi  = band_q;
   assign in_band  = inb_q;
   assign band_chg = chg_q;
endmodule

// File: rtl/bsel_checker.sv
module bsel_checker #(
   parameter int WIN_CYCLES = 35080
) (
   input logic clk,
   input logic rst,
   input logic band_hi,
   input logic band_chg,
   input logic in_band
);
   localparam int TW = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;

   // independent phase counter: 0 in the cycle after each window closes
   logic [TW-1:0] ph_q;
   always_ff @(posedge clk) begin
      if (rst)                              ph_q <= '0;
      else if (ph_q == TW'(WIN_CYCLES - 1)) ph_q <= '0;
      else                                  ph_q <= ph_q + 1'b1;
   end

   p_hold_midwindow_r2: assert property (@(posedge clk) disable iff (rst)
      (ph_q != '0) |-> ($stable(band_hi) && $stable(in_band)));

   p_hi_needs_inband_r4: assert property (@(posedge clk) disable iff (rst)
      $rose(band_hi) |-> in_band);

   p_gap_keeps_band_r5: assert property (@(posedge clk) disable iff (rst)
      !in_band |-> $stable(band_hi));

   p_chg_on_flip_r7: assert property (@(posedge clk) disable iff (rst)
      band_chg |-> (band_hi != $past(band_hi)));

   p_flip_gives_chg_r7: assert property (@(posedge clk) disable iff (rst)
      (band_hi != $past(band_hi)) |-> band_chg);

   p_chg_single_r7: assert property (@(posedge clk) disable iff (rst)
      band_chg |=> !band_chg);
endmodule

bind band_selector bsel_checker #(.WIN_CYCLES(WIN_CYCLES)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .band_hi (band_hi),
   .band_chg(band_chg),
   .in_band (in_band)
);

// File: tb/band_selector_bench.sv
module band_selector_bench;
   localparam int W      = 160;
   localparam int LO_MIN = 3;
   localparam int LO_MAX = 6;
   localparam int HI_MIN = 9;
   localparam int HI_MAX = 21;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sq_in = 1'b0;
   logic band_hi, band_chg, in_band;

   int total = 0;
   int bad = 0;
   bit done = 0;

   logic e_band = 1'b0;
   logic e_inb  = 1'b0;
   logic e_chg  = 1'b0;
   logic s_band, s_inb;

   always #10 clk = ~clk;

   band_selector #(
      .WIN_CYCLES (W),
      .LO_MIN     (LO_MIN),
      .LO_MAX     (LO_MAX),
      .HI_MIN     (HI_MIN),
      .HI_MAX     (HI_MAX),
      .SYNC_STAGES(2)
   ) u_band_selector (
      .clk     (clk),
      .rst     (rst),
      .sq_in   (sq_in),
      .band_hi (band_hi),
      .band_chg(band_chg),
      .in_band (in_band)
   );

   task automatic check(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   // 0 none, 1 low, 2 high; counts above 31 saturate and stay out of band (R8)
   function automatic int cls_of(input int n);
      int s;
      s = (n > 31) ? 31 : n;
      if (s >= LO_MIN && s <= LO_MAX) return 1;
      if (s >= HI_MIN && s <= HI_MAX) return 2;
      return 0;
   endfunction

   function automatic logic pat(input int i, input int n, input int per, input int hw);
      int d;
      if (i < 4 || n == 0) return 1'b0;
      d = i - 4;
      if ((d / per) < n && (d % per) < hw) return 1'b1;
      return 1'b0;
   endfunction

   // one window: cycle 0 checks the previous verdict, then drives n edges
   task automatic run_window(input int n, input int per, input int hw, input string tag);
      int c;
      for (int i = 0; i < W; i++) begin
         if (i == 0) begin
            check({tag, " in_band"}, in_band, e_inb);
            check({tag, " band_hi"}, band_hi, e_band);
            check({tag, " R7 band_chg pulse"}, band_chg, e_chg);
            s_band = band_hi;
            s_inb  = in_band;
         end
         if (i == 1) check("R7 band_chg one cycle", band_chg, 1'b0);
         if (i == W / 2) begin
            check("R2 band_hi held mid-window", band_hi, s_band);
            check("R2 in_band held mid-window", in_band, s_inb);
         end
         sq_in = pat(i, n, per, hw);
         @(negedge clk);
      end
      c = cls_of(n);
      if (c == 1) begin
         e_chg = (e_band == 1'b1); e_band = 1'b0; e_inb = 1'b1;
      end else if (c == 2) begin
         e_chg = (e_band == 1'b0); e_band = 1'b1; e_inb = 1'b1;
      end else begin
         e_chg = 1'b0; e_inb = 1'b0;
      end
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0613));
      repeat (4) @(negedge clk);
      check("R1 reset band_hi", band_hi, 1'b0);
      check("R1 reset in_band", in_band, 1'b0);
      check("R1 reset band_chg", band_chg, 1'b0);
      rst = 1'b0;

      run_window(4, 4, 2, "R1 first window");  // R1 also covers cycle 0
      run_window(0, 4, 2, "R3 low lo");        // checks the 4-edge verdict
      run_window(12, 4, 2, "R5 none after silence");
      run_window(15, 4, 2, "R4 high flip");
      run_window(7, 4, 2, "R6 stay high");
      run_window(8, 4, 2, "R5 gap 7");
      run_window(22, 4, 2, "R5 gap 8");
      run_window(35, 4, 2, "R5 above");
      run_window(3, 4, 1, "R8 saturate 35");
      run_window(6, 4, 3, "R3 low edge 3");
      run_window(9, 4, 2, "R6 low 6");
      run_window(21, 4, 1, "R4 high 9");
      run_window(4, 30, 25, "R4 high 21");
      run_window(2, 50, 45, "R9 long highs 4");
      run_window(32, 4, 2, "R5 count 2");
      run_window(10, 12, 11, "R8 saturate 32");
      run_window(0, 4, 2, "R9 long highs 10");

      for (int r = 0; r < 30; r++) begin
         int n, per, pmax, hw;
         n = $urandom_range(0, 36);
         pmax = (n > 1) ? 148 / n : 100;
         if (pmax > 40) pmax = 40;
         per = $urandom_range(4, pmax);
         hw = $urandom_range(1, per - 1);
         run_window(n, per, hw, "R3 R4 R5 random");
      end
      run_window(0, 4, 2, "R6 random tail");

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule